// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block takes a single-data-rate SDRAM from power-up to normal operation. After reset it holds the clock enable low with the command bus deselected for the power-up settle time. It then issues a NOP with the clock enable raised and a precharge of all banks, each followed by a timed wait. Next it runs two auto-refresh phases of fixed length: the first with a short refresh interval, the second with the nominal 15.625 µs interval. Finally it writes the mode register through the address bus and, after a settle wait, reports completion.

All nanosecond and microsecond figures are parameters. They are turned into cycle counts at elaboration from the clock frequency parameter. The refresh interval is published in units of 16 clocks, so a downstream refresh engine can take it over. The mode word is placed on the host-side address bus at a shift that follows from the bus width, the column bits and the bank bits. A precharge-all carries only the bit that reaches device pin A10.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and for exactly cyc(100 µs) cycles after it is released (10000 at 100 MHz), cke is 0, cs_n is 1, init_done is 0 and ref_units is 0. The first command is then a NOP ({cs_n,ras_n,cas_n,we_n} = 0111), issued with cke at 1. Here cyc(t) is ceil(t × f), with a minimum of 1.
- R2: cke never drops once it has risen, until the next reset. Whenever cke is 0, cs_n is 1. Cycles that carry no command are deselect cycles (cs_n = 1).
- R3: A precharge-all (0010) follows exactly cyc(10 µs) after the first NOP. Its addr carries a single set bit, at position MODE_SHIFT+10 (bit 22 by default).
- R4: A second NOP follows exactly cyc(1 µs) after the precharge-all. The fast refresh phase starts cyc(1 µs) after that NOP.
- R5: ref_units stays 0 until the fast phase. It equals floor(200 ns × f)/16 + 1 (2 at 100 MHz) during the fast phase, and floor(15625 ns × f)/16 + 1 (98 at 100 MHz) from the nominal phase onward. Each phase lasts cyc(10 µs).
- R6: In each refresh phase, an AUTO REFRESH (0001) is issued ref_units×16 cycles after the phase starts and again every ref_units×16 cycles after that. A refresh is suppressed when fewer than cyc(tRFC) cycles of the phase remain. At 100 MHz this gives 31 refreshes, 32 cycles apart, and none in the nominal phase.
- R7: The mode-register write (0000) is issued as the nominal phase ends, 2·cyc(10 µs) after the fast phase starts. It has ba = 0 and addr = ((CAS latency 3 << 4) | burst code 2) << MODE_SHIFT, which is 0x32000. Bit 3 is 0, which selects a sequential burst. MODE_SHIFT = log2(bus bytes) + column bits + bank bits = 12.
- R8: init_done rises exactly cyc(10 µs) after the mode write and stays high. From then on every cycle is a deselect with cke at 1.
- R9: After a refresh the next command is at least cyc(63 ns) cycles later. After a precharge-all it is at least cyc(20 ns) cycles later. After a mode write it is at least cyc(30 ns) cycles later.
- R10: Asserting reset at any point returns the outputs to the R1 state, and the whole sequence restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W (24) | Host-side address carrying A10 and the mode word |
| ba | output | BANK_BITS (2) | Bank address |
| ref_units | output | REF_W (12) | Programmed refresh interval in 16-clock units |
| init_done | output | 1 | High once normal operation is reached |

## Verification
The bench keeps the default parameters: a 100 MHz clock, a 32-bit bus, 8 column bits and 4 banks. Every wait is then an exact cycle count, and the mode address is 0x32000. With the fast interval at 32 cycles, the 31st refresh lands exactly where the remaining phase time equals tRFC (7 cycles), so the suppression boundary is exercised at its edge. The nominal interval of 1568 cycles is longer than its 1000-cycle phase, so that phase is checked to contain no refresh at all.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_MHZ      = 100,
  parameter int BUS_BITS     = 32,
  parameter int COL_BITS     = 8,
  parameter int ROW_BITS     = 12,
  parameter int BANK_BITS    = 2,
  parameter int CAS_LAT      = 3,
  parameter int BURST_CODE   = 2,
  parameter int PWRUP_NS     = 100000,
  parameter int NOP_WAIT_NS  = 10000,
  parameter int PALL_WAIT_NS = 1000,
  parameter int NOP2_WAIT_NS = 1000,
  parameter int REF_PHASE_NS = 10000,
  parameter int MODE_WAIT_NS = 10000,
  parameter int REF_FAST_NS  = 200,
  parameter int REF_NOM_NS   = 15625,
  parameter int T_RP_NS      = 20,
  parameter int T_RFC_NS     = 63,
  parameter int T_MRD_NS     = 30,
  parameter int REF_UNIT     = 16,
  parameter int REF_W        = 12,
  localparam int MODE_SHIFT  = $clog2(BUS_BITS/8) + COL_BITS + BANK_BITS,
  localparam int ADDR_W      = MODE_SHIFT + ROW_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 cke,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [ADDR_W-1:0]    addr,
  output logic [BANK_BITS-1:0] ba,
  output logic [REF_W-1:0]     ref_units,
  output logic                 init_done
);

  function automatic int ns2cyc(input longint ns);
    longint c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_RP   = ns2cyc(T_RP_NS);
  localparam int T_RFC  = ns2cyc(T_RFC_NS);
  localparam int T_MRD  = ns2cyc(T_MRD_NS);
  localparam int T_PWR  = imax(ns2cyc(PWRUP_NS), 2);
  localparam int T_NW   = imax(ns2cyc(NOP_WAIT_NS), 2);
  localparam int T_PW   = imax(imax(ns2cyc(PALL_WAIT_NS), T_RP), 2);
  localparam int T_N2   = imax(ns2cyc(NOP2_WAIT_NS), 2);
  localparam int T_PH   = imax(ns2cyc(REF_PHASE_NS), T_RFC + 1);
  localparam int T_MW   = imax(imax(ns2cyc(MODE_WAIT_NS), T_MRD), 2);
  localparam int FAST_U = (REF_FAST_NS * CLK_MHZ / 1000) / REF_UNIT + 1;
  localparam int NOM_U  = (REF_NOM_NS * CLK_MHZ / 1000) / REF_UNIT + 1;
  localparam int FAST_C = FAST_U * REF_UNIT;
  localparam int NOM_C  = NOM_U * REF_UNIT;
  localparam int MAXT   = imax(imax(imax(T_PWR, T_NW), imax(T_PW, T_N2)), imax(T_PH, T_MW));
  localparam int CW     = $clog2(MAXT + 1);
  localparam int RCW    = $clog2(imax(FAST_C, NOM_C) + 1);
  localparam int MODE_WORD = (CAS_LAT << 4) | BURST_CODE;

  typedef enum logic [3:0] {
    ST_PWR, ST_NOP1, ST_W1, ST_PALL, ST_W2, ST_NOP2, ST_W3,
    ST_RFAST, ST_RNOM, ST_MRS, ST_W4, ST_DONE
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [RCW-1:0] rcnt;
  logic           in_ref, do_ref, cnt_z, rcnt_z;

  assign cnt_z  = (cnt == '0);
  assign rcnt_z = (rcnt == '0);
  assign in_ref = (st == ST_RFAST) || (st == ST_RNOM);
  assign do_ref = in_ref && rcnt_z && (cnt >= CW'(T_RFC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PWR;
      cnt       <= CW'(T_PWR - 1);
      rcnt      <= '0;
      ref_units <= '0;
    end else begin
      case (st)
        ST_PWR:  if (cnt_z) st <= ST_NOP1; else cnt <= cnt - 1'b1;
        ST_NOP1: begin st <= ST_W1; cnt <= CW'(T_NW - 2); end
        ST_W1:   if (cnt_z) st <= ST_PALL; else cnt <= cnt - 1'b1;
        ST_PALL: begin st <= ST_W2; cnt <= CW'(T_PW - 2); end
        ST_W2:   if (cnt_z) st <= ST_NOP2; else cnt <= cnt - 1'b1;
        ST_NOP2: begin st <= ST_W3; cnt <= CW'(T_N2 - 2); end
        ST_W3: begin
          if (cnt_z) begin
            st        <= ST_RFAST;
            cnt       <= CW'(T_PH - 1);
            rcnt      <= RCW'(FAST_C);
            ref_units <= REF_W'(FAST_U);
          end else cnt <= cnt - 1'b1;
        end
        ST_RFAST: begin
          if (cnt_z) begin
            st        <= ST_RNOM;
            cnt       <= CW'(T_PH - 1);
            rcnt      <= RCW'(NOM_C);
            ref_units <= REF_W'(NOM_U);
          end else begin
            cnt  <= cnt - 1'b1;
            rcnt <= rcnt_z ? RCW'(FAST_C - 1) : rcnt - 1'b1;
          end
        end
        ST_RNOM: begin
          if (cnt_z) st <= ST_MRS;
          else begin
            cnt  <= cnt - 1'b1;
            rcnt <= rcnt_z ? RCW'(NOM_C - 1) : rcnt - 1'b1;
          end
        end
        ST_MRS:  begin st <= ST_W4; cnt <= CW'(T_MW - 2); end
        ST_W4:   if (cnt_z) st <= ST_DONE; else cnt <= cnt - 1'b1;
        default: st <= ST_DONE;
      endcase
    end
  end

  logic [3:0] cmd;
  always_comb begin
    cmd = 4'b1111;
    if (st == ST_NOP1 || st == ST_NOP2) cmd = 4'b0111;
    else if (st == ST_PALL)             cmd = 4'b0010;
    else if (st == ST_MRS)              cmd = 4'b0000;
    else if (do_ref)                    cmd = 4'b0001;
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = (st != ST_PWR);
  assign init_done = (st == ST_DONE);
  assign ba        = '0;
  assign addr      = (st == ST_PALL) ? (ADDR_W'(1) << (MODE_SHIFT + 10)) :
                     (st == ST_MRS)  ? (ADDR_W'(MODE_WORD) << MODE_SHIFT) : '0;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int AW = 24,
  parameter int BW = 2,
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic [BW-1:0] ba,
  input logic [RW-1:0] ref_units,
  input logic          init_done
);
  logic is_ref, is_pall, is_mrs;
  assign is_ref  = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_pall = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_mrs  = !cs_n && !ras_n && !cas_n && !we_n;

  // R2
  inhibit_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> cs_n);
  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke);
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done);
  // R8
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> (cs_n && cke));
  // R9
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) is_ref |=> cs_n);
  // R3
  pall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n) is_pall |-> ($countones(addr) == 1));
  // R7
  mrs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n) is_mrs |-> (ba == '0));
  // R5
  ref_units_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (is_ref || init_done) |-> (ref_units != '0));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.AW(ADDR_W), .BW(BANK_BITS), .RW(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .ba(ba), .ref_units(ref_units), .init_done(init_done)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [23:0] addr;
  logic [1:0]  ba;
  logic [11:0] ref_units;

  sdram_init_seq dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .ref_units(ref_units), .init_done(init_done)
  );

  localparam int C_NOP = 7, C_PALL = 2, C_REF = 1, C_MRS = 0;
  localparam int T_RFC = 7, T_RP = 2, T_MRD = 3;
  localparam int VEC_CODE [4] = '{C_NOP, C_PALL, C_NOP, C_MRS};
  localparam int VEC_AT   [4] = '{10000, 11000, 11100, 13200};
  localparam int VEC_REQ  [4] = '{1, 3, 4, 7};

  int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;
  int cyc = 0;
  int n_lg = 0;
  int lg_cyc [64];
  int lg_cmd [64];
  logic [23:0] lg_addr [64];
  logic [11:0] lg_ru [64];
  bit have_last = 0;
  int last_cmd = 0, last_cyc = 0;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_lg = 0;
      have_last = 0;
    end else if (!cs_n) begin
      int code, mn;
      code = {ras_n, cas_n, we_n};
      if (have_last) begin
        mn = (last_cmd == C_REF) ? T_RFC : (last_cmd == C_PALL) ? T_RP : (last_cmd == C_MRS) ? T_MRD : 1;
        mon_checks++;
        if (cyc - last_cyc < mn) begin
          mon_errors++;
          $display("FAIL R9: gap %0d after cmd %0d, expected >= %0d", cyc - last_cyc, last_cmd, mn);
        end
      end
      have_last = 1; last_cmd = code; last_cyc = cyc;
      if (n_lg < 64) begin
        lg_cyc[n_lg] = cyc; lg_cmd[n_lg] = code; lg_addr[n_lg] = addr; lg_ru[n_lg] = ref_units;
        n_lg++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end

  initial begin
    int j, nref, first_ref, prev_ref;
    repeat (3) @(negedge clk);
    chk(!cke && cs_n && !init_done && ref_units == 0, "R1 reset state", {cke, cs_n, init_done}, 3'b010);
    rst_n = 1'b1;
    while (cyc < 9999) @(negedge clk);
    chk(!cke && cs_n, "R1 cke low before first NOP", cke, 0);
    while (!init_done && cyc < 20000) @(negedge clk);
    chk(cyc == 14200, "R8 init_done cycle", cyc, 14200);
    chk(ref_units == 98, "R5 nominal ref_units", ref_units, 98);
    repeat (20) @(negedge clk);
    chk(cs_n && cke && init_done, "R8 idle after done", {cs_n, cke, init_done}, 3'b111);

    j = 0; nref = 0; first_ref = -1; prev_ref = -1;
    for (int i = 0; i < n_lg; i++) begin
      if (lg_cmd[i] == C_REF) begin
        if (first_ref < 0) first_ref = lg_cyc[i];
        else chk(lg_cyc[i] - prev_ref == 32, "R6 refresh spacing", lg_cyc[i] - prev_ref, 32);
        chk(lg_ru[i] == 2, "R5 fast ref_units", lg_ru[i], 2);
        chk(lg_cyc[i] < 12200, "R6 no refresh in nominal phase", lg_cyc[i], 12200);
        prev_ref = lg_cyc[i];
        nref++;
      end else begin
        if (j < 4) begin
          chk(lg_cmd[i] == VEC_CODE[j], $sformatf("R%0d command code", VEC_REQ[j]), lg_cmd[i], VEC_CODE[j]);
          chk(lg_cyc[i] == VEC_AT[j], $sformatf("R%0d command cycle", VEC_REQ[j]), lg_cyc[i], VEC_AT[j]);
          if (j == 1) chk(lg_addr[i] == 24'h400000, "R3 precharge-all address", lg_addr[i], 24'h400000);
          if (j == 2) chk(lg_ru[i] == 0, "R5 ref_units before fast phase", lg_ru[i], 0);
          if (j == 3) chk(lg_addr[i] == 24'h032000, "R7 mode address", lg_addr[i], 24'h032000);
        end
        j++;
      end
    end
    chk(j == 4, "R7 non-refresh command count", j, 4);
    chk(nref == 31, "R6 refresh count", nref, 31);
    chk(first_ref == 11232, "R6 first refresh cycle", first_ref, 11232);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    while (cyc < 11500) @(negedge clk);
    chk(cke && ref_units == 2, "R4 in fast phase before mid reset", ref_units, 2);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!cke && cs_n && ref_units == 0 && !init_done, "R10 outputs after mid reset", {cke, cs_n, init_done}, 3'b010);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    while (n_lg < 1 && cyc < 10100) @(negedge clk);
    chk(n_lg >= 1 && lg_cyc[0] == 10000 && lg_cmd[0] == C_NOP, "R10 restart first NOP", lg_cyc[0], 10000);
    chk(cke, "R1 cke high after restart NOP", cke, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule